// File: doc/BRIEF.md
# Two-Stage Operand-Isolated ALU

A 16-bit arithmetic logic unit with a two-stage pipeline. Each cycle in which the input strobe is high, the unit accepts two operands and a 4-bit operation code. Two clock edges later it presents the result, four status flags and an output strobe. Sixteen operations are provided: six arithmetic, nine bitwise/move and one compare.

The arithmetic path is a parallel-prefix adder. Bitwise propagate and generate cells feed four combining levels. The logic path has its own operand registers and its own propagate/generate cells, so the propagate signal reaches the sum XOR stage and the logic result mux on separate buses. The first stage decodes the operation. It loads only the operand registers of the path that the operation needs, and the other path keeps its previous inputs and does not toggle. An idle cycle loads no operand register.

Add-with-carry and subtract-with-borrow take their carry from the carry flag. They read that flag in the second stage, so an operation issued on the cycle right after the one that sets the flag sees the new value.

Top module: `opiso_alu`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `res`, all four flags and `out_vld` to 0 (synchronous reset).
- R2: An operation accepted at edge k (`in_vld` high) appears at edge k+1 with `out_vld` high for exactly one cycle. With no accepted operation one edge earlier, `out_vld` is low.
- R3: Arithmetic opcodes: 0 ADD gives a+b. 1 SUB gives a+~b+1. 4 INC gives a+1. 5 DEC gives a+0xFFFF. All results are mod 2^16. Carry is the bit-16 carry-out, so after SUB a carry of 1 means no borrow. Overflow is set when the signed result lies outside the 16-bit signed range.
- R4: 2 ADC gives a+b+C and 3 SBB gives a+~b+C, where C is the carry flag left by the previous operation, including an operation issued on the immediately preceding cycle.
- R5: Logic opcodes give: 6 a&b, 7 a|b, 8 a^b, 9 ~(a^b), 10 ~(a&b), 11 ~(a|b), 12 ~a, 13 a, 14 b.
- R6: Every completed operation sets zero to (value==0) and negative to bit 15 of its value. Logic opcodes clear carry and overflow.
- R7: 15 CMP computes a+~b+1 and updates all four flags from it, but leaves `res` unchanged.
- R8: A logic operation leaves the adder operand registers unchanged.
- R9: An arithmetic operation or CMP leaves the logic operand registers unchanged.
- R10: An idle cycle (`in_vld` low) changes no operand register. Once the pipeline drains, `res` and the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| res | output | 16 | Registered result |
| flg_z | output | 1 | Zero flag |
| flg_n | output | 1 | Negative flag |
| flg_c | output | 1 | Carry-out flag |
| flg_v | output | 1 | Signed overflow flag |
| out_vld | output | 1 | Result strobe |

## Verification
Two things can happen in the same clock cycle: stage two writes the carry flag for one operation while stage one captures a following add-with-carry or subtract-with-borrow. The bench provokes this by issuing an all-ones add and then a carry-consuming operation on back-to-back cycles. It judges the second result against a model in which the fresh carry is used. Alternating arithmetic and logic operations back to back drive the other overlap: one path is captured while the other computes. Each result is compared with an independently computed reference.

// File: rtl/opiso_alu.sv
module opiso_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         flg_z,
  output logic         flg_n,
  output logic         flg_c,
  output logic         flg_v,
  output logic         out_vld
);
  localparam int L = $clog2(W);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_ADC = 4'd2, OP_SBB = 4'd3,
                         OP_INC = 4'd4, OP_DEC = 4'd5, OP_AND = 4'd6, OP_OR  = 4'd7,
                         OP_XOR = 4'd8, OP_XNR = 4'd9, OP_NND = 4'd10, OP_NOR = 4'd11,
                         OP_NTA = 4'd12, OP_PSA = 4'd13, OP_PSB = 4'd14, OP_CMP = 4'd15;

  // stage 1: decode and isolated operand capture
  logic         is_arith;
  logic [W-1:0] bsel;
  logic [1:0]   csel_d;
  assign is_arith = (op <= OP_DEC) || (op == OP_CMP);

  always_comb begin
    bsel   = b;
    csel_d = 2'd0;
    case (op)
      OP_SUB, OP_CMP: begin bsel = ~b; csel_d = 2'd1; end
      OP_ADC:         begin bsel = b;  csel_d = 2'd2; end
      OP_SBB:         begin bsel = ~b; csel_d = 2'd2; end
      OP_INC:         begin bsel = '0; csel_d = 2'd1; end
      OP_DEC:         begin bsel = '1; csel_d = 2'd0; end
      default:        begin bsel = b;  csel_d = 2'd0; end
    endcase
  end

  logic [W-1:0] ax, bx, lx, ly;
  logic [1:0]   csel;
  logic [3:0]   s1_op;
  logic         s1_arith, s1_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      ax <= '0; bx <= '0; lx <= '0; ly <= '0;
      csel <= 2'd0; s1_op <= 4'd0; s1_arith <= 1'b0; s1_vld <= 1'b0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_op    <= op;
        s1_arith <= is_arith;
        if (is_arith) begin
          ax <= a; bx <= bsel; csel <= csel_d;
        end else begin
          lx <= a; ly <= b;
        end
      end
    end
  end

  // stage 2: prefix adder
  logic [L:0][W-1:0] gt, pt;
  logic [W:0]        cv;
  logic [W-1:0]      sum;
  logic              cin, ovf;

  assign cin   = (csel == 2'd2) ? flg_c : csel[0];
  assign gt[0] = ax & bx;
  assign pt[0] = ax ^ bx;

  for (genvar k = 0; k < L; k++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= (1 << k)) begin : g_cmb
        assign gt[k+1][i] = gt[k][i] | (pt[k][i] & gt[k][i-(1<<k)]);
        assign pt[k+1][i] = pt[k][i] & pt[k][i-(1<<k)];
      end else begin : g_pas
        assign gt[k+1][i] = gt[k][i];
        assign pt[k+1][i] = pt[k][i];
      end
    end
  end

  assign cv[0]     = cin;
  assign cv[W:1]   = gt[L] | (pt[L] & {W{cin}});
  assign sum       = pt[0] ^ cv[W-1:0];
  assign ovf       = (ax[W-1] == bx[W-1]) && (sum[W-1] != ax[W-1]);

  // stage 2: logic unit on its own propagate/generate bus
  logic [W-1:0] lp, lg, lres, rnew;
  assign lp = lx ^ ly;
  assign lg = lx & ly;

  always_comb begin
    case (s1_op)
      OP_AND:  lres = lg;
      OP_OR:   lres = lp | lg;
      OP_XOR:  lres = lp;
      OP_XNR:  lres = ~lp;
      OP_NND:  lres = ~lg;
      OP_NOR:  lres = ~(lp | lg);
      OP_NTA:  lres = ~lx;
      OP_PSA:  lres = lx;
      OP_PSB:  lres = ly;
      default: lres = lp;
    endcase
  end

  assign rnew = s1_arith ? sum : lres;

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0; flg_z <= 1'b0; flg_n <= 1'b0; flg_c <= 1'b0; flg_v <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        if (s1_op != OP_CMP) res <= rnew;
        flg_z <= (rnew == '0);
        flg_n <= rnew[W-1];
        flg_c <= s1_arith & cv[W];
        flg_v <= s1_arith & ovf;
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_vld == $past(s1_vld)));
  a_r8_adder_frozen: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !is_arith) |=> ($stable(ax) && $stable(bx)));
  a_r9_logic_frozen: assert property (@(posedge clk) disable iff (rst)
    (in_vld && is_arith) |=> ($stable(lx) && $stable(ly)));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(ax) && $stable(bx) && $stable(lx) && $stable(ly)));
  a_r7_cmp_keeps: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_op == OP_CMP) |=> $stable(res));
  a_r6_logic_clears: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !s1_arith) |=> (!flg_c && !flg_v));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (armed && !s1_vld) |=> !out_vld);
endmodule

// File: tb/sim_opiso_alu.sv
module sim_opiso_alu;
  logic        clk = 1'b0, rst = 1'b1, in_vld = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] res;
  logic        flg_z, flg_n, flg_c, flg_v, out_vld;
  int total = 0, bad = 0;
  logic [15:0] mr = '0;
  logic        mz = 0, mn = 0, mc = 0, mv = 0;

  opiso_alu u0 (.clk(clk), .rst(rst), .in_vld(in_vld), .op(op), .a(a), .b(b),
                .res(res), .flg_z(flg_z), .flg_n(flg_n), .flg_c(flg_c),
                .flg_v(flg_v), .out_vld(out_vld));

  always #2.5 clk = ~clk;

  function automatic logic [17:0] refop(input logic [3:0] o, input logic [15:0] x, y, input logic c);
    int u, sg, sx, sy;
    logic [15:0] r;
    sx = int'($signed(x)); sy = int'($signed(y));
    u = 0; sg = 0;
    case (o)
      4'd0: begin u = x + y;                  sg = sx + sy; end
      4'd1, 4'd15: begin u = x + (~y & 16'hFFFF) + 1; sg = sx - sy; end
      4'd2: begin u = x + y + c;              sg = sx + sy + c; end
      4'd3: begin u = x + (~y & 16'hFFFF) + c; sg = sx - sy - (1 - c); end
      4'd4: begin u = x + 1;                  sg = sx + 1; end
      4'd5: begin u = x + 16'hFFFF;           sg = sx - 1; end
      default: ;
    endcase
    if (o <= 4'd5 || o == 4'd15)
      return {u[16], (sg > 32767 || sg < -32768), u[15:0]};
    case (o)
      4'd6: r = x & y;   4'd7: r = x | y;   4'd8: r = x ^ y;
      4'd9: r = ~(x ^ y); 4'd10: r = ~(x & y); 4'd11: r = ~(x | y);
      4'd12: r = ~x;     4'd13: r = x;      default: r = y;
    endcase
    return {2'b00, r};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model(input logic [3:0] o, input logic [15:0] x, y);
    logic [17:0] t;
    t = refop(o, x, y, mc);
    if (o != 4'd15) mr = t[15:0];
    mz = (t[15:0] == 16'h0); mn = t[15];
    mc = t[17]; mv = t[16];
  endtask

  task automatic verify(input string tag);
    chk({tag, " out_vld"}, {31'd0, out_vld}, 32'd1);
    chk({tag, " res"}, {16'd0, res}, {16'd0, mr});
    chk({tag, " flags"}, {28'd0, flg_z, flg_n, flg_c, flg_v}, {28'd0, mz, mn, mc, mv});
  endtask

  task automatic issue(input logic [3:0] o, input logic [15:0] x, y);
    @(negedge clk); op = o; a = x; b = y; in_vld = 1'b1;
  endtask

  task automatic idle;
    @(negedge clk); in_vld = 1'b0; a = $urandom; b = $urandom; op = $urandom;
  endtask

  task automatic single(input logic [3:0] o, input logic [15:0] x, y, input string tag);
    issue(o, x, y); idle; @(negedge clk);
    model(o, x, y); verify(tag);
  endtask

  task automatic pair(input logic [3:0] o1, input logic [15:0] x1, y1,
                      input logic [3:0] o2, input logic [15:0] x2, y2, input string tag);
    issue(o1, x1, y1); issue(o2, x2, y2); idle;
    model(o1, x1, y1); verify({tag, " first"});
    @(negedge clk);
    model(o2, x2, y2); verify({tag, " second"});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 res", {16'd0, res}, 32'd0);
    chk("R1 flags", {28'd0, flg_z, flg_n, flg_c, flg_v}, 32'd0);
    chk("R1 out_vld", {31'd0, out_vld}, 32'd0);
  endtask

  task automatic t_arith;
    single(4'd0, 16'h7FFF, 16'h0001, "R3 add signed ovf");
    single(4'd0, 16'hFFFF, 16'h0001, "R3 add carry zero");
    single(4'd1, 16'h0005, 16'h0007, "R3 sub borrow");
    single(4'd1, 16'h0007, 16'h0005, "R3 sub no borrow");
    single(4'd1, 16'h8000, 16'h0001, "R3 sub ovf");
    single(4'd4, 16'hFFFF, 16'h1234, "R3 inc wrap");
    single(4'd5, 16'h0000, 16'h1234, "R3 dec zero");
    single(4'd5, 16'h8000, 16'h0000, "R3 dec ovf");
  endtask

  task automatic t_carry_chain;
    pair(4'd0, 16'hFFFF, 16'hFFFF, 4'd2, 16'h0010, 16'h0020, "R4 add then adc");
    pair(4'd1, 16'h0001, 16'h0002, 4'd3, 16'h0100, 16'h0001, "R4 sub then sbb");
    pair(4'd1, 16'h0009, 16'h0002, 4'd3, 16'h0100, 16'h0001, "R4 sub then sbb nb");
  endtask

  task automatic t_logic;
    for (int k = 6; k <= 14; k++) begin
      single(4'd0, 16'h8000, 16'h8000, "R6 preset c v");
      single(4'(k), 16'hF0A5, 16'h3C0F, $sformatf("R5 R6 logic op %0d", k));
    end
    single(4'd6, 16'h00FF, 16'hFF00, "R6 and zero");
    single(4'd11, 16'h0000, 16'h0000, "R6 nor neg");
  endtask

  task automatic t_cmp;
    single(4'd13, 16'h1234, 16'h0000, "R7 preload");
    single(4'd15, 16'h1234, 16'h1234, "R7 cmp equal");
    single(4'd15, 16'h0001, 16'h0002, "R7 cmp less");
  endtask

  task automatic t_isolation;
    pair(4'd0, 16'h1111, 16'h2222, 4'd8, 16'hAAAA, 16'h5555, "R8 R9 arith then logic");
    pair(4'd7, 16'h0F00, 16'h00F0, 4'd1, 16'h3000, 16'h0001, "R8 R9 logic then arith");
    pair(4'd14, 16'hBEEF, 16'hCAFE, 4'd2, 16'h0001, 16'h0001, "R8 logic then adc");
  endtask

  task automatic t_idle;
    single(4'd0, 16'h0102, 16'h0304, "R10 setup");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R2 R10 idle out_vld", {31'd0, out_vld}, 32'd0);
      chk("R10 idle res", {16'd0, res}, {16'd0, mr});
      chk("R10 idle flags", {28'd0, flg_z, flg_n, flg_c, flg_v}, {28'd0, mz, mn, mc, mv});
    end
  endtask

  initial begin
    #10000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_arith;
    t_carry_chain;
    t_logic;
    t_cmp;
    t_isolation;
    t_idle;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule